// File: doc/BRIEF.md
# Zero-Page Read-Modify-Write Bus Sequencer

This block produces the memory bus cycles of an 8-bit processor's zero-page read-modify-write instructions (increment, decrement, shift left, shift right, rotate left, rotate right) in direct zero-page and zero-page-indexed forms. The decoder pulses `start` with the operation code, the zero-page operand byte, the X index, the carry flag and a cycle-policy mode. The block then drives one bus cycle per clock until the modified byte has been written back. A small ALU forms the new byte and its N, Z and C flags.

The mode input selects what happens between the operand read and the result write. In the classic policy, an idle cycle rewrites the unmodified byte to the target. In the CMOS policy, the idle cycle reads the target a second time, so the target sees only one write. In the streamlined policy there is no idle cycle. When the parallel index adder is built in, the streamlined indexed form also skips the separate indexing cycle. `done` marks the final write cycle, so the opcode fetch of the next instruction can be scheduled into the slot that follows.

Top module: `zp_rmw_seq`

## Requirements
- R1: After reset, `busy`, `done` and `wr_en` are 0, and `addr` and `wr_data` are 0.
- R2: For the direct form (`indexed`=0), the bus cycles from the first busy cycle through the `done` cycle number 3 in classic mode (`mode`=00), 3 in CMOS mode (01) and 2 in streamlined mode (10).
- R3: For the indexed form (`indexed`=1), the cycle count is 4 in classic and CMOS modes. In streamlined mode it is 2 when `HAS_IDX_ADDER`=1 and 3 when `HAS_IDX_ADDER`=0.
- R4: In classic mode, the cycle after the operand read writes the unmodified operand to the operand address. The next cycle writes the result to the same address, so there are exactly two writes.
- R5: In CMOS mode, the cycle after the operand read is a second read of the operand address. The result write follows, so there is exactly one write.
- R6: In streamlined mode, the result write occurs in the cycle directly after the operand read, and there is exactly one write.
- R7: Every bus address is `{8'h00, ea}`, where `ea` = (`zp_addr` + `x_idx`) mod 256 for the indexed form and `zp_addr` for the direct form. In classic and CMOS indexed accesses, the first cycle is a read of `{8'h00, zp_addr}`.
- R8: The written result uses these operation codes: 0 increment, 1 decrement, 2 shift left with 0 in, 3 shift right with 0 in, 4 rotate left through `carry_in`, 5 rotate right through `carry_in`. Increment and decrement wrap modulo 256.
- R9: The cycle after `done`, `flag_n` holds result bit 7 and `flag_z` is 1 when the result is 0. `flag_c` holds bit 7 of the operand for codes 2 and 4, bit 0 of the operand for codes 3 and 5, and `carry_in` for codes 0 and 1.
- R10: `busy` is 1 from the cycle after `start` through the `done` cycle. `done` is 1 only in the final write cycle. `busy` is 0 in the cycle after `done`.
- R11: `start` is ignored while `busy` is 1. The running access keeps its address and length, and no second access follows.
- R12: Mode 11 behaves as the CMOS mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an access (accepted when idle) |
| op | input | 3 | Operation code |
| indexed | input | 1 | 1 selects the zero-page-indexed form |
| mode | input | 2 | Dead-cycle policy: 00 classic, 01 CMOS, 10 streamlined, 11 as CMOS |
| zp_addr | input | 8 | Zero-page operand byte |
| x_idx | input | 8 | X index register value |
| carry_in | input | 1 | Carry flag before the operation |
| rd_data | input | 8 | Read data from memory |
| addr | output | 16 | Bus address |
| wr_data | output | 8 | Bus write data |
| wr_en | output | 1 | 1 = write cycle, 0 = read or idle |
| busy | output | 1 | Access in progress |
| done | output | 1 | Final write cycle of the access |
| flag_n | output | 1 | Negative flag of the last result |
| flag_z | output | 1 | Zero flag of the last result |
| flag_c | output | 1 | Carry flag of the last result |

## Verification
The bench builds two copies of the block side by side. The main copy uses the default `HAS_IDX_ADDER`=1, which brings the two-cycle streamlined indexed path within reach. A second copy uses `HAS_IDX_ADDER`=0, which exposes the three-cycle streamlined indexed path, where the index is added in a bus cycle of its own. Both copies run with an 8-bit data path and a 16-bit address, so wrap of the indexed sum past 0xFF and the forced zero high address byte are both observable.

// File: rtl/zp_rmw_pkg.sv
package zp_rmw_pkg;

  localparam logic [2:0] OP_INC = 3'd0;
  localparam logic [2:0] OP_DEC = 3'd1;
  localparam logic [2:0] OP_ASL = 3'd2;
  localparam logic [2:0] OP_LSR = 3'd3;
  localparam logic [2:0] OP_ROL = 3'd4;
  localparam logic [2:0] OP_ROR = 3'd5;

  localparam logic [1:0] MODE_CLASSIC = 2'b00;
  localparam logic [1:0] MODE_CMOS    = 2'b01;
  localparam logic [1:0] MODE_STREAM  = 2'b10;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_IDX  = 3'd1,
    ST_RD   = 3'd2,
    ST_DEAD = 3'd3,
    ST_WR   = 3'd4
  } seq_state_e;

endpackage

// File: rtl/zp_rmw_alu.sv
module zp_rmw_alu #(
  parameter int DW = 8
) (
  input  logic [2:0]    op,
  input  logic [DW-1:0] operand,
  input  logic          cin,
  output logic [DW-1:0] result,
  output logic          res_n,
  output logic          res_z,
  output logic          res_c
);
  import zp_rmw_pkg::*;

  localparam int MSB = DW - 1;

  always_comb begin
    result = operand;
    res_c  = cin;
    unique case (op)
      OP_INC: result = operand + DW'(1);
      OP_DEC: result = operand - DW'(1);
      OP_ASL: begin
        result = {operand[MSB-1:0], 1'b0};
        res_c  = operand[MSB];
      end
      OP_LSR: begin
        result = {1'b0, operand[MSB:1]};
        res_c  = operand[0];
      end
      OP_ROL: begin
        result = {operand[MSB-1:0], cin};
        res_c  = operand[MSB];
      end
      OP_ROR: begin
        result = {cin, operand[MSB:1]};
        res_c  = operand[0];
      end
      default: begin
        result = operand;
        res_c  = cin;
      end
    endcase
    res_n = result[MSB];
    res_z = (result == '0);
  end

endmodule

// File: rtl/zp_rmw_agen.sv
module zp_rmw_agen #(
  parameter int DW = 8,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          pre_index,
  input  logic          step_index,
  input  logic [DW-1:0] base,
  input  logic [DW-1:0] idx,
  input  logic          drive,
  output logic [AW-1:0] bus_addr
);
  localparam int HI_W = AW - DW;

  logic [DW-1:0] ea_q, ea_d, idx_q, idx_d;
  logic          ea_en;

  always_comb begin
    ea_en = load | step_index;
    idx_d = load ? idx : idx_q;
    ea_d  = ea_q;
    if (load) begin
      ea_d = pre_index ? (base + idx) : base;
    end else if (step_index) begin
      ea_d = ea_q + idx_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ea_q  <= '0;
      idx_q <= '0;
    end else begin
      if (ea_en) ea_q <= ea_d;
      if (load)  idx_q <= idx_d;
    end
  end

  assign bus_addr = drive ? {{HI_W{1'b0}}, ea_q} : '0;

  assert_addr_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (drive && $past(drive) && !$past(step_index)) |-> $stable(bus_addr));

endmodule

// File: rtl/zp_rmw_ctl.sv
module zp_rmw_ctl #(
  parameter bit HAS_IDX_ADDER = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [2:0]             op_in,
  input  logic                   indexed_in,
  input  logic [1:0]             mode_in,
  input  logic                   cin_in,
  output zp_rmw_pkg::seq_state_e state,
  output logic [2:0]             op_q,
  output logic                   cin_q,
  output logic                   load,
  output logic                   pre_index,
  output logic                   step_index,
  output logic                   capture,
  output logic                   commit,
  output logic                   write_old,
  output logic                   busy,
  output logic                   done,
  output logic                   wr_en
);
  import zp_rmw_pkg::*;

  seq_state_e state_q, state_d;
  logic [1:0] mode_q;
  logic       stream_q, classic_q, stream_in;

  assign stream_in = (mode_in == MODE_STREAM);
  assign stream_q  = (mode_q == MODE_STREAM);
  assign classic_q = (mode_q == MODE_CLASSIC);

  generate
    if (HAS_IDX_ADDER) begin : g_par_adder
      assign pre_index = indexed_in & stream_in;
    end else begin : g_serial_adder
      assign pre_index = 1'b0;
    end
  endgenerate

  assign load = (state_q == ST_IDLE) && start;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start) state_d = (indexed_in && !pre_index) ? ST_IDX : ST_RD;
      ST_IDX:  state_d = ST_RD;
      ST_RD:   state_d = stream_q ? ST_WR : ST_DEAD;
      ST_DEAD: state_d = ST_WR;
      ST_WR:   state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= '0;
      mode_q  <= MODE_CLASSIC;
      cin_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (load) begin
        op_q   <= op_in;
        mode_q <= mode_in;
        cin_q  <= cin_in;
      end
    end
  end

  assign state      = state_q;
  assign step_index = (state_q == ST_IDX);
  assign capture    = (state_q == ST_RD);
  assign commit     = (state_q == ST_WR);
  assign write_old  = (state_q == ST_DEAD) && classic_q;
  assign busy       = (state_q != ST_IDLE);
  assign done       = (state_q == ST_WR);
  assign wr_en      = done | write_old;

  assert_done_ends_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  assert_classic_two_writes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && classic_q) |-> $past(wr_en));
  assert_cmos_one_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !classic_q && !stream_q) |-> !$past(wr_en));
  assert_stream_no_dead_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && stream_q) |-> $past(state_q == ST_RD));
  assert_capture_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(op_q) && $stable(mode_q) && $stable(cin_q)));

endmodule

// File: rtl/zp_rmw_seq.sv
module zp_rmw_seq #(
  parameter int DW            = 8,
  parameter int AW            = 16,
  parameter bit HAS_IDX_ADDER = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    op,
  input  logic          indexed,
  input  logic [1:0]    mode,
  input  logic [DW-1:0] zp_addr,
  input  logic [DW-1:0] x_idx,
  input  logic          carry_in,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] wr_data,
  output logic          wr_en,
  output logic          busy,
  output logic          done,
  output logic          flag_n,
  output logic          flag_z,
  output logic          flag_c
);
  import zp_rmw_pkg::*;

  seq_state_e    state;
  logic [2:0]    op_q;
  logic          cin_q, load, pre_index, step_index, capture, commit, write_old;
  logic [DW-1:0] opnd_q, alu_res;
  logic          alu_n, alu_z, alu_c;

  zp_rmw_ctl #(.HAS_IDX_ADDER(HAS_IDX_ADDER)) u_ctl (
    .clk(clk), .rst_n(rst_n), .start(start), .op_in(op), .indexed_in(indexed),
    .mode_in(mode), .cin_in(carry_in), .state(state), .op_q(op_q), .cin_q(cin_q),
    .load(load), .pre_index(pre_index), .step_index(step_index), .capture(capture),
    .commit(commit), .write_old(write_old), .busy(busy), .done(done), .wr_en(wr_en)
  );

  zp_rmw_agen #(.DW(DW), .AW(AW)) u_agen (
    .clk(clk), .rst_n(rst_n), .load(load), .pre_index(pre_index),
    .step_index(step_index), .base(zp_addr), .idx(x_idx), .drive(busy),
    .bus_addr(addr)
  );

  zp_rmw_alu #(.DW(DW)) u_alu (
    .op(op_q), .operand(opnd_q), .cin(cin_q), .result(alu_res),
    .res_n(alu_n), .res_z(alu_z), .res_c(alu_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opnd_q <= '0;
      flag_n <= 1'b0;
      flag_z <= 1'b0;
      flag_c <= 1'b0;
    end else begin
      if (capture) opnd_q <= rd_data;
      if (commit) begin
        flag_n <= alu_n;
        flag_z <= alu_z;
        flag_c <= alu_c;
      end
    end
  end

  always_comb begin
    wr_data = '0;
    if (commit)         wr_data = alu_res;
    else if (write_old) wr_data = opnd_q;
  end

  assert_write_same_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(busy)) |-> $stable(addr));
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!wr_en && addr == '0));
  assert_old_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !done) |-> (wr_data == $past(rd_data)));

endmodule

// File: tb/zp_rmw_seq_test.sv
`timescale 1ns/1ps
module zp_rmw_seq_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start;
  logic [2:0] op;
  logic       indexed;
  logic [1:0] mode;
  logic [7:0] zp_addr, x_idx;
  logic       carry_in;
  logic [7:0] mem_addr_t, mem_val_t;
  logic [7:0] rd_data, s_rd_data;
  logic [15:0] addr, s_addr;
  logic [7:0] wr_data, s_wr_data;
  logic       wr_en, busy, done, flag_n, flag_z, flag_c;
  logic       s_wr_en, s_busy, s_done, s_n, s_z, s_c;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #4 clk = ~clk;

  assign rd_data   = (addr[7:0]   == mem_addr_t) ? mem_val_t : 8'hEE;
  assign s_rd_data = (s_addr[7:0] == mem_addr_t) ? mem_val_t : 8'hEE;

  zp_rmw_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .indexed(indexed), .mode(mode),
    .zp_addr(zp_addr), .x_idx(x_idx), .carry_in(carry_in), .rd_data(rd_data),
    .addr(addr), .wr_data(wr_data), .wr_en(wr_en), .busy(busy), .done(done),
    .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c)
  );

  zp_rmw_seq #(.HAS_IDX_ADDER(1'b0)) uut_ser (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .indexed(indexed), .mode(mode),
    .zp_addr(zp_addr), .x_idx(x_idx), .carry_in(carry_in), .rd_data(s_rd_data),
    .addr(s_addr), .wr_data(s_wr_data), .wr_en(s_wr_en), .busy(s_busy), .done(s_done),
    .flag_n(s_n), .flag_z(s_z), .flag_c(s_c)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [10:0] ref_alu(input logic [2:0] o, input logic [7:0] v,
                                          input logic ci);
    logic [7:0] r;
    logic c;
    r = v; c = ci;
    case (o)
      3'd0: r = v + 8'd1;
      3'd1: r = v - 8'd1;
      3'd2: begin r = {v[6:0], 1'b0}; c = v[7]; end
      3'd3: begin r = {1'b0, v[7:1]}; c = v[0]; end
      3'd4: begin r = {v[6:0], ci};   c = v[7]; end
      3'd5: begin r = {ci, v[7:1]};   c = v[0]; end
      default: ;
    endcase
    return {r[7], (r == 8'd0), c, r};
  endfunction

  // One access on the main unit; compares the whole bus sequence with the model.
  task automatic run_case(input string rq_seq, input logic [2:0] o, input bit ix,
                          input logic [1:0] md, input logic [7:0] zp,
                          input logic [7:0] xv, input bit ci, input logic [7:0] val);
    logic [7:0]  ea;
    logic [10:0] ref_v;
    bit          exp_wr[8];
    logic [7:0]  exp_a[8], exp_d[8];
    bit          got_wr[8], got_done[8];
    logic [15:0] got_a[8];
    logic [7:0]  got_d[8];
    int n_exp, n, k, wcount;
    string rq_cnt;
    ea     = ix ? (zp + xv) : zp;
    ref_v  = ref_alu(o, val, ci);
    rq_cnt = ix ? "R3" : "R2";
    k = 0;
    if (ix && md != 2'b10) begin exp_wr[k] = 0; exp_a[k] = zp; exp_d[k] = 0; k++; end
    exp_wr[k] = 0; exp_a[k] = ea; exp_d[k] = 0; k++;
    if (md == 2'b00) begin exp_wr[k] = 1; exp_a[k] = ea; exp_d[k] = val; k++; end
    else if (md != 2'b10) begin exp_wr[k] = 0; exp_a[k] = ea; exp_d[k] = 0; k++; end
    exp_wr[k] = 1; exp_a[k] = ea; exp_d[k] = ref_v[7:0]; k++;
    n_exp = k;

    @(negedge clk);
    op = o; indexed = ix; mode = md; zp_addr = zp; x_idx = xv; carry_in = ci;
    mem_addr_t = ea; mem_val_t = val; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    for (int i = 0; i < 8; i++) begin
      if (!busy) break;
      got_wr[i] = wr_en; got_a[i] = addr; got_d[i] = wr_data; got_done[i] = done;
      n++;
      if (done) break;
      @(negedge clk);
    end
    chk(n == n_exp, rq_cnt, "cycle count", n, n_exp);
    wcount = 0;
    for (int i = 0; i < n && i < n_exp; i++) begin
      chk(got_a[i] == {8'h00, exp_a[i]}, "R7", $sformatf("address c%0d", i), got_a[i], exp_a[i]);
      chk(got_wr[i] == exp_wr[i], rq_seq, $sformatf("direction c%0d", i), got_wr[i], exp_wr[i]);
      if (exp_wr[i] && i < n_exp - 1)
        chk(got_d[i] == exp_d[i], rq_seq, "dead-cycle data", got_d[i], exp_d[i]);
      chk(got_done[i] == (i == n_exp - 1), "R10", $sformatf("done c%0d", i), got_done[i], (i == n_exp - 1));
      if (got_wr[i]) wcount++;
    end
    chk(got_d[n-1] == ref_v[7:0], "R8", "result byte", got_d[n-1], ref_v[7:0]);
    chk(wcount == ((md == 2'b00) ? 2 : 1), rq_seq, "write count", wcount, (md == 2'b00) ? 2 : 1);
    @(negedge clk);
    chk(!busy, "R10", "busy after done", busy, 0);
    chk({flag_n, flag_z, flag_c} == ref_v[10:8], "R9", "flags N Z C", {flag_n, flag_z, flag_c}, ref_v[10:8]);
  endtask

  task automatic test_reset;
    chk(!busy && !done && !wr_en, "R1", "idle strobes", {busy, done, wr_en}, 0);
    chk(addr == 16'h0 && wr_data == 8'h0, "R1", "idle bus", addr, 0);
  endtask

  task automatic test_start_ignored;
    int n;
    bit addr_ok;
    @(negedge clk);
    op = 3'd0; indexed = 1'b0; mode = 2'b00; zp_addr = 8'h10; x_idx = 8'h00;
    carry_in = 1'b0; mem_addr_t = 8'h10; mem_val_t = 8'h41; start = 1'b1;
    @(negedge clk);
    zp_addr = 8'h55; mode = 2'b10; op = 3'd1;
    n = 0; addr_ok = 1;
    for (int i = 0; i < 8; i++) begin
      if (!busy) break;
      n++;
      if (addr != 16'h0010) addr_ok = 0;
      if (done) begin
        chk(wr_data == 8'h42, "R11", "result kept original op", wr_data, 8'h42);
        break;
      end
      @(negedge clk);
    end
    start = 1'b0;
    chk(n == 3, "R11", "length unchanged", n, 3);
    chk(addr_ok, "R11", "address unchanged", addr_ok, 1);
    @(negedge clk);
    @(negedge clk);
    chk(!busy, "R11", "no queued access", busy, 0);
  endtask

  task automatic test_serial_index;
    int n;
    logic [7:0] last_d;
    @(negedge clk);
    op = 3'd0; indexed = 1'b1; mode = 2'b10; zp_addr = 8'hF8; x_idx = 8'h10;
    carry_in = 1'b0; mem_addr_t = 8'h08; mem_val_t = 8'h0F; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0; last_d = 8'h00;
    for (int i = 0; i < 8; i++) begin
      if (!s_busy) break;
      n++;
      last_d = s_wr_data;
      if (s_done) break;
      @(negedge clk);
    end
    chk(n == 3, "R3", "serial-adder streamlined indexed count", n, 3);
    chk(last_d == 8'h10, "R3", "serial-adder result", last_d, 8'h10);
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; op = '0; indexed = 1'b0; mode = '0;
    zp_addr = '0; x_idx = '0; carry_in = 1'b0; mem_addr_t = '0; mem_val_t = '0;
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    run_case("R4", 3'd0, 1'b0, 2'b00, 8'h20, 8'h00, 1'b0, 8'h7F);
    run_case("R4", 3'd2, 1'b1, 2'b00, 8'hF0, 8'h20, 1'b0, 8'hC1);
    run_case("R5", 3'd1, 1'b0, 2'b01, 8'h33, 8'h00, 1'b1, 8'h01);
    run_case("R5", 3'd3, 1'b1, 2'b01, 8'h40, 8'h05, 1'b0, 8'h81);
    run_case("R6", 3'd4, 1'b0, 2'b10, 8'h80, 8'h00, 1'b1, 8'h80);
    run_case("R6", 3'd5, 1'b1, 2'b10, 8'hFF, 8'h01, 1'b1, 8'h02);
    run_case("R12", 3'd0, 1'b0, 2'b11, 8'h07, 8'h00, 1'b0, 8'hFF);
    run_case("R12", 3'd1, 1'b1, 2'b11, 8'h90, 8'h90, 1'b0, 8'h00);
    run_case("R6", 3'd2, 1'b1, 2'b10, 8'h01, 8'h02, 1'b1, 8'h80);
    test_start_ignored();
    test_serial_index();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected below 20000 cycles", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule